// File: doc/BRIEF.md
# Integer ALU with NZCV Flags

This block is the data-processing unit of a 64-bit integer pipeline that can also work on 32-bit values. It takes two operands, an opcode, a width select, an extract amount and the current carry. From these it produces a result in the same cycle. The result covers add and subtract, with and without carry-in, six bitwise operations, variable shifts, rotate-right and a two-register extract.

A four-bit NZCV flag register sits next to the datapath. It loads new flags on a clock edge only when the set-flags input is high. The surrounding pipeline decodes instructions, reads registers and supplies the carry. It then takes the result combinationally and the flags from the register.

Top module: `int_alu_flags`

## Requirements
- R1: Opcode 0 returns A+B and opcode 1 returns A+B+carry_in, both modulo the active width.
- R2: Opcode 2 returns A-B and opcode 3 returns A-B-(1-carry_in), so a set carry means no borrow.
- R3: For opcodes 0 to 3 with set_flags high, the flags become N = result sign, Z = result zero, C = unsigned carry-out (for subtraction: no borrow) and V = signed overflow. The flags are held as flags_q = {N,Z,C,V}, N at bit 3.
- R4: The bitwise opcodes return the following: 4 gives A AND B, 5 gives A AND NOT B, 6 gives A OR B, 7 gives A OR NOT B, 8 gives A XOR B and 9 gives A XOR NOT B.
- R5: For every opcode from 4 upward with set_flags high, C and V are cleared, and N and Z follow the result.
- R6: Shift and rotate counts come from B modulo the width: the low 6 bits in 64-bit mode and the low 5 bits in 32-bit mode.
- R7: Opcode 10 shifts left and opcode 11 shifts right logically, both zero-filling. Opcode 12 shifts right arithmetically, copying the sign bit of the active width.
- R8: Opcode 13 rotates A right by the count, with bits leaving at bit 0 re-entering at the top of the active width.
- R9: Opcode 14 (extract) returns the active-width window starting at bit s of the concatenation {A,B}, with B in the low half. s is ext_amt taken modulo the width, so s = 0 returns B.
- R10: When wide is low, result bits 63:32 are zero, and N, C and V come from bit 31 and from the 32-bit carry and overflow.
- R11: flags_q resets to 0000, loads on a rising clock edge only when set_flags is high, and holds otherwise. Opcode 15 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Operation select (encodings in R1-R11) |
| wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand, also the shift count |
| ext_amt | input | 6 | Extract bit position |
| carry_in | input | 1 | Carry used by the with-carry opcodes |
| set_flags | input | 1 | Load the flag register on this edge |
| result | output | 64 | Combinational result |
| flags_q | output | 4 | Registered {N,Z,C,V} |

## Verification
The only state in the block is the flag register. A wrong load or a missed hold shows on flags_q one edge after the offending cycle. The bench therefore compares flags_q at every falling edge against a model that loads only on set_flags. Datapath faults (wrong carry polarity, a count masked to the wrong width, upper bits leaking in 32-bit mode) show on the result in the same cycle. They show on C or V one edge later. The vectors cover zero and full-width counts, carry-chain extremes and sign boundaries in both widths.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_BIC  = 4'd5,
    OP_ORR  = 4'd6,
    OP_ORN  = 4'd7,
    OP_EOR  = 4'd8,
    OP_EON  = 4'd9,
    OP_LSL  = 4'd10,
    OP_LSR  = 4'd11,
    OP_ASR  = 4'd12,
    OP_ROR  = 4'd13,
    OP_EXTR = 4'd14,
    OP_NONE = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  input  logic         wide,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         v_out
);
  localparam int H = W / 2;

  logic [W-1:0] bx;
  logic [W:0]   full_s;
  logic [H:0]   half_s;
  logic         sa, sb, sr;

  always_comb begin
    bx     = sub ? ~b : b;
    full_s = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};
    half_s = {1'b0, a[H-1:0]} + {1'b0, bx[H-1:0]} + {{H{1'b0}}, cin};
    sum    = wide ? full_s[W-1:0] : {{H{1'b0}}, half_s[H-1:0]};
    c_out  = wide ? full_s[W] : half_s[H];
    sa     = wide ? a[W-1]      : a[H-1];
    sb     = wide ? bx[W-1]     : bx[H-1];
    sr     = wide ? full_s[W-1] : half_s[H-1];
    v_out  = (sa == sb) && (sr != sa);
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_pkg::*;
#(
  parameter int W = 64
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_BIC:  y = a & ~b;
      OP_ORR:  y = a | b;
      OP_ORN:  y = a | ~b;
      OP_EOR:  y = a ^ b;
      OP_EON:  y = a ^ ~b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int W  = 64,
  parameter int SW = $clog2(W)
) (
  input  alu_op_e       op,
  input  logic          wide,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [SW-1:0] ext_amt,
  output logic [W-1:0]  y
);
  localparam int H = W / 2;

  logic [SW-1:0] amt, es;
  logic [SW:0]   span;
  logic [W-1:0]  a_z, a_s, b_z;

  always_comb begin
    amt  = wide ? b[SW-1:0] : {1'b0, b[SW-2:0]};
    es   = wide ? ext_amt   : {1'b0, ext_amt[SW-2:0]};
    span = wide ? (SW+1)'(W) : (SW+1)'(H);
    a_z  = wide ? a : {{H{1'b0}}, a[H-1:0]};
    a_s  = wide ? a : {{H{a[H-1]}}, a[H-1:0]};
    b_z  = wide ? b : {{H{1'b0}}, b[H-1:0]};
    unique case (op)
      OP_LSL:  y = a_z << amt;
      OP_LSR:  y = a_z >> amt;
      OP_ASR:  y = W'($signed(a_s) >>> amt);
      OP_ROR:  y = (amt == '0) ? a_z
                 : ((a_z >> amt) | (a_z << (span - {1'b0, amt})));
      OP_EXTR: y = (es == '0) ? b_z
                 : ((b_z >> es) | (a_z << (span - {1'b0, es})));
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
  import alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_code,
  input  logic              wide,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [SH_W-1:0]   ext_amt,
  input  logic              carry_in,
  input  logic              set_flags,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        flags_q
);
  localparam int HALF_W = DATA_W / 2;

  alu_op_e           op;
  logic              is_arith, is_bit, is_sh;
  logic              add_sub, add_cin, add_c, add_v;
  logic [DATA_W-1:0] add_y, bit_y, sh_y, raw_y;
  nzcv_t             fl_new, fl_d, fl_q;

  assign op       = alu_op_e'(op_code);
  assign is_arith = (op_code <= 4'd3);
  assign is_bit   = (op_code >= 4'd4) && (op_code <= 4'd9);
  assign is_sh    = (op_code >= 4'd10) && (op_code <= 4'd14);

  always_comb begin
    add_sub = (op == OP_SUB) || (op == OP_SBC);
    unique case (op)
      OP_ADD:  add_cin = 1'b0;
      OP_SUB:  add_cin = 1'b1;
      default: add_cin = carry_in;
    endcase
  end

  alu_addsub #(.W(DATA_W)) u_add (
    .a(opnd_a), .b(opnd_b), .sub(add_sub), .cin(add_cin), .wide(wide),
    .sum(add_y), .c_out(add_c), .v_out(add_v)
  );

  alu_bitwise #(.W(DATA_W)) u_bit (
    .op(op), .a(opnd_a), .b(opnd_b), .y(bit_y)
  );

  alu_shift #(.W(DATA_W), .SW(SH_W)) u_sh (
    .op(op), .wide(wide), .a(opnd_a), .b(opnd_b), .ext_amt(ext_amt), .y(sh_y)
  );

  always_comb begin
    if (is_arith)    raw_y = add_y;
    else if (is_bit) raw_y = bit_y;
    else if (is_sh)  raw_y = sh_y;
    else             raw_y = '0;
    result = wide ? raw_y : {{HALF_W{1'b0}}, raw_y[HALF_W-1:0]};
  end

  // next-state of flag register
  always_comb begin
    fl_new.n = wide ? result[DATA_W-1] : result[HALF_W-1];
    fl_new.z = (result == '0);
    fl_new.c = is_arith & add_c;
    fl_new.v = is_arith & add_v;
    fl_d     = set_flags ? fl_new : fl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= '0;
    else        fl_q <= fl_d;
  end

  assign flags_q = fl_q;

  // R11: flags hold when no load requested
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !set_flags |=> flags_q == $past(flags_q));

  // R5: non-arithmetic flag loads clear C and V
  a_r5_cv_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && !is_arith) |=> flags_q[1:0] == 2'b00);

  // R10: narrow mode leaves upper half zero
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> result[DATA_W-1:HALF_W] == '0);

  // R3: Z flag tracks the result that was loaded
  a_r3_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> flags_q[2] == ($past(result) == '0));

  // R3: N flag follows the sign bit of the active width
  a_r3_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    set_flags |=> flags_q[3] == $past(wide ? result[DATA_W-1] : result[HALF_W-1]));

  // R9: extract by zero returns the second operand
  a_r9_extr_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && op == OP_EXTR && ext_amt == '0) |-> result == opnd_b);
endmodule

// File: tb/sim_int_alu_flags.sv
module sim_int_alu_flags;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op_code;
  logic        wide;
  logic [63:0] opnd_a, opnd_b;
  logic [5:0]  ext_amt;
  logic        carry_in, set_flags;
  logic [63:0] result;
  logic [3:0]  flags_q;

  int compared   = 0;
  int mismatched = 0;
  logic [3:0] exp_flags;
  bit done = 0;

  always #10 clk = ~clk;

  int_alu_flags u0 (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .wide(wide),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .ext_amt(ext_amt),
    .carry_in(carry_in), .set_flags(set_flags),
    .result(result), .flags_q(flags_q)
  );

  function automatic string tag_of(input logic [3:0] op);
    if (op <= 4'd1) return "R1";
    if (op <= 4'd3) return "R2";
    if (op <= 4'd9) return "R4";
    if (op <= 4'd11) return "R6";
    if (op == 4'd12) return "R7";
    if (op == 4'd13) return "R8";
    if (op == 4'd14) return "R9";
    return "R11";
  endfunction

  function automatic logic signed [66:0] sx(input logic [63:0] v, input bit w);
    return w ? {{3{v[63]}}, v} : {{35{v[31]}}, v[31:0]};
  endfunction

  function automatic logic signed [66:0] zx(input logic [63:0] v, input bit w);
    return w ? {3'b0, v} : {35'b0, v[31:0]};
  endfunction

  task automatic ref_model(input logic [3:0] op, input bit w, input logic [63:0] a,
                           input logic [63:0] b, input logic [5:0] es_in, input bit cin,
                           output logic [63:0] y, output logic [3:0] f);
    int width = w ? 64 : 32;
    int n = w ? int'(b[5:0]) : int'(b[4:0]);
    int s = w ? int'(es_in) : int'(es_in[4:0]);
    logic signed [66:0] us, ss, lim_hi, lim_lo, ulim;
    logic [127:0] cat;
    logic c = 0, v = 0;
    y = '0;
    lim_hi = w ? 67'sh7FFFFFFFFFFFFFFF : 67'sh7FFFFFFF;
    lim_lo = -lim_hi - 1;
    ulim   = w ? (67'sd1 <<< 64) : (67'sd1 <<< 32);
    case (op)
      4'd0, 4'd1: begin
        us = zx(a, w) + zx(b, w) + ((op == 4'd1 && cin) ? 67'sd1 : 67'sd0);
        ss = sx(a, w) + sx(b, w) + ((op == 4'd1 && cin) ? 67'sd1 : 67'sd0);
        c = (us >= ulim); v = (ss > lim_hi) || (ss < lim_lo);
        y = us[63:0];
      end
      4'd2, 4'd3: begin
        logic signed [66:0] bor = (op == 4'd3 && !cin) ? 67'sd1 : 67'sd0;
        us = zx(a, w) - zx(b, w) - bor;
        ss = sx(a, w) - sx(b, w) - bor;
        c = (us >= 0); v = (ss > lim_hi) || (ss < lim_lo);
        y = us[63:0];
      end
      4'd4: y = a & b;
      4'd5: y = a & ~b;
      4'd6: y = a | b;
      4'd7: y = a | ~b;
      4'd8: y = a ^ b;
      4'd9: y = ~(a ^ b);
      4'd10: for (int i = 0; i < width; i++) y[i] = (i >= n) ? a[i-n] : 1'b0;
      4'd11: for (int i = 0; i < width; i++) y[i] = (i + n < width) ? a[i+n] : 1'b0;
      4'd12: for (int i = 0; i < width; i++) y[i] = (i + n < width) ? a[i+n] : a[width-1];
      4'd13: for (int i = 0; i < width; i++) y[i] = a[(i + n) % width];
      4'd14: begin
        cat = '0;
        for (int i = 0; i < width; i++) begin cat[i] = b[i]; cat[i+width] = a[i]; end
        for (int i = 0; i < width; i++) y[i] = cat[i+s];
      end
      default: y = '0;
    endcase
    if (!w) y[63:32] = '0;
    f = {w ? y[63] : y[31], y == 64'd0, c, v};
  endtask

  task automatic apply(input logic [3:0] op, input bit w, input logic [63:0] a,
                       input logic [63:0] b, input logic [5:0] es, input bit cin,
                       input bit sf);
    logic [63:0] ey;
    logic [3:0]  ef;
    @(negedge clk);
    compared++;
    if (flags_q !== exp_flags) begin
      mismatched++;
      $display("FAIL R3/R5/R11 flags: actual %b expected %b", flags_q, exp_flags);
    end
    op_code = op; wide = w; opnd_a = a; opnd_b = b; ext_amt = es;
    carry_in = cin; set_flags = sf;
    #1;
    ref_model(op, w, a, b, es, cin, ey, ef);
    compared++;
    if (result !== ey) begin
      mismatched++;
      $display("FAIL %s%s op %0d: actual %h expected %h", tag_of(op),
               w ? "" : "/R10", op, result, ey);
    end
    if (sf) exp_flags = ef;
  endtask

  initial begin
    #4000000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 0; op_code = 0; wide = 1; opnd_a = 0; opnd_b = 0;
    ext_amt = 0; carry_in = 0; set_flags = 0; exp_flags = 4'b0000;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R11: reset state
    apply(4'd0, 1, 64'd5, 64'd7, 0, 0, 0);
    // R1 / R3: unsigned carry and signed overflow in both widths
    apply(4'd0, 1, 64'hFFFFFFFFFFFFFFFF, 64'd1, 0, 0, 1);
    apply(4'd0, 1, 64'h7FFFFFFFFFFFFFFF, 64'd1, 0, 0, 1);
    apply(4'd1, 1, 64'd10, 64'd20, 0, 1, 1);
    apply(4'd1, 0, 64'hAAAA_0000_FFFF_FFFF, 64'd0, 0, 1, 1);
    apply(4'd0, 0, 64'h0000_0000_7FFF_FFFF, 64'd1, 0, 0, 1);
    // R2: borrow polarity
    apply(4'd2, 1, 64'd5, 64'd5, 0, 0, 1);
    apply(4'd2, 1, 64'd3, 64'd5, 0, 1, 1);
    apply(4'd3, 1, 64'd9, 64'd4, 0, 0, 1);
    apply(4'd3, 1, 64'd9, 64'd4, 0, 1, 1);
    apply(4'd3, 0, 64'h8000_0000, 64'd1, 0, 1, 1);
    apply(4'd2, 1, 64'h8000000000000000, 64'd1, 0, 1, 1);
    // R5: C/V cleared after arithmetic set them
    apply(4'd0, 1, 64'hFFFFFFFFFFFFFFFF, 64'h8000000000000000, 0, 0, 1);
    apply(4'd5, 1, 64'hF0F0, 64'hFF00, 0, 0, 1);
    apply(4'd4, 1, 64'h8000000000000001, 64'h8000000000000000, 0, 0, 1);
    // R11: hold without set_flags
    apply(4'd2, 1, 64'd0, 64'd1, 0, 0, 0);
    apply(4'd0, 1, 64'd0, 64'd0, 0, 0, 0);
    // R4: bitwise
    for (int k = 4; k <= 9; k++) begin
      apply(4'(k), 1, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_F0F0_3C3C_A5A5, 0, 0, 1);
      apply(4'(k), 0, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_F0F0_3C3C_A5A5, 0, 0, 1);
    end
    // R6/R7/R8: counts at edges and above width
    for (int k = 10; k <= 13; k++) begin
      apply(4'(k), 1, 64'h8000_0001_8000_0001, 64'd0, 0, 0, 1);
      apply(4'(k), 1, 64'h8000_0001_8000_0001, 64'd63, 0, 0, 1);
      apply(4'(k), 1, 64'h8000_0001_8000_0001, 64'd68, 0, 0, 1);
      apply(4'(k), 0, 64'hFFFF_0000_8000_0001, 64'd31, 0, 0, 1);
      apply(4'(k), 0, 64'hFFFF_0000_8000_0001, 64'd33, 0, 0, 1);
    end
    // R9: extract
    apply(4'd14, 1, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, 6'd0, 0, 1);
    apply(4'd14, 1, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, 6'd16, 0, 1);
    apply(4'd14, 1, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, 6'd63, 0, 1);
    apply(4'd14, 0, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, 6'd8, 0, 1);
    apply(4'd14, 0, 64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, 6'd32, 0, 1);
    // R11: unused opcode
    apply(4'd15, 1, 64'hFFFF, 64'hFFFF, 0, 1, 1);
    // mixed patterns over all opcodes and both widths
    for (int k = 0; k < 600; k++) begin
      logic [63:0] ra = {$urandom, $urandom};
      logic [63:0] rb = {$urandom, $urandom};
      if (k % 7 == 0) ra = {ra[63], 63'd0};
      if (k % 11 == 0) rb = ~ra;
      apply(4'($urandom_range(0, 15)), bit'($urandom_range(0, 1)), ra, rb,
            6'($urandom), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end
    apply(4'd0, 1, 64'd0, 64'd0, 0, 0, 0);
    // R11: asynchronous reset clears flags
    @(negedge clk);
    rst_n = 0; #1;
    compared++;
    if (flags_q !== 4'b0000) begin
      mismatched++;
      $display("FAIL R11 reset: actual %b expected 0000", flags_q);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule